// File: doc/BRIEF.md
# Four-Port Overlapped Seek Manager

This block lets a host start head-positioning operations on up to four disk drive ports at once. Each port's positioner runs on its own, so a long seek on one drive does not hold up a short seek on another. The host sends a 12-bit seek command that names the port and the target track. The block checks whether that port can take the command and, if it can, pulses the port's seek strobe with the track value. Commands that cannot be accepted are dropped, and the port's busy-error bit records the rejection.

For each port the block keeps a 3-bit status field. It holds a hardware seek error, a busy error and a live not-ready indication. The four fields are packed into one 12-bit word that the host can read at any time. A drive fault during a seek sets the hardware error and fires an automatic restore strobe to that port. When a seek ends, the block raises a one-cycle done request, but only if no data transfer is running. It also raises an interrupt request when interrupts are enabled. A master clear input wipes all error bits and abandons any seek in progress.

The command input is a valid/ready stream. `cmd_ready` is held high, so there is never back-pressure: a word is taken on every clock edge at which `cmd_valid` is high, and at most one command is taken per cycle. All other pins are plain level or pulse signals.

Top module: `seek_overlap_mgr`

## Requirements
- R1: A command word is split as follows: bits [11:10] give the port number and bits [9:0] give the target track. `cmd_ready` is always high. The cycle after an accepted seek, `seek_strobe[p]` is high for exactly one cycle, and `seek_track` slice p holds the track. At most one strobe is high in any cycle.
- R2: `seek_status[3p+2:3p]` is the field of port p. Port 0 is in bits [2:0] and port 3 is in bits [11:9].
- R3: Within a field, bit 2 is the hardware seek error and bit 1 is the busy error. Bit 0 is the not-ready bit: it is 1 while the port's seek is in progress or while the drive's ready input is low.
- R4: A port whose present input is low reads 3'b111 in its field.
- R5: A seek is rejected if the port is absent, is not ready, already has a seek in progress, or is the port of an active data transfer. A rejected seek sets the port's busy error and produces no strobe.
- R6: An accepted command clears the port's hardware error and busy error.
- R7: A target track greater than the port's maximum-track input sets the hardware error. In that case there is no strobe and no seek is started.
- R8: A fault input during a seek ends the seek, sets the hardware error and produces a one-cycle restore strobe to that port.
- R9: When a seek ends (by completion or by fault), `done_o` pulses for one cycle on the next cycle. This happens only if `xfer_active` was low when the seek ended; otherwise no done pulse is produced.
- R10: `irq_o` pulses together with `done_o` when `irq_en` was high; otherwise it stays low.
- R11: Master clear resets the busy error and hardware error of every port and abandons any seek in progress.
- R12: Seeks on different ports run concurrently, and each one completes on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Synchronous master clear |
| cmd_valid | input | 1 | Seek command valid |
| cmd_ready | output | 1 | Always high; command taken whenever valid |
| cmd_word | input | 12 | Port number [11:10], target track [9:0] |
| xfer_active | input | 1 | A data transfer is running |
| xfer_port | input | 2 | Port used by the running transfer |
| irq_en | input | 1 | Interrupt enable |
| drv_present | input | 4 | Drive attached, one bit per port |
| drv_ready | input | 4 | Drive ready, one bit per port |
| drv_seek_done | input | 4 | Seek-complete pulse, one bit per port |
| drv_fault | input | 4 | Seek-fault pulse, one bit per port |
| max_track | input | 40 | Highest legal track per port, 10 bits each |
| seek_strobe | output | 4 | Start-seek strobe per port |
| seek_track | output | 40 | Latched target track per port, 10 bits each |
| restore_strobe | output | 4 | Automatic restore strobe per port |
| seek_status | output | 12 | Packed per-port status fields |
| done_o | output | 1 | Done request pulse |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The assertions check the following on every cycle. At most one seek strobe fires at a time, and a strobe's track never exceeds that port's limit. A strobe always comes with clean error bits, and a restore always comes with a set hardware error and an idle port. A command on the transfer port always ends up as a busy error. Master clear always leaves a port clean and idle. A done pulse never follows a seek end that happened during a transfer.

The bench scenarios cover the rest:
- how the packed word looks for absent, not-ready, moving and failed ports;
- drive models with different latencies finishing out of order;
- the done pulse being suppressed during a transfer;
- the interrupt depending on the enable;
- a seek abandoned by master clear, whose late completion is ignored.

// File: rtl/seek_pkg.sv
package seek_pkg;
  localparam int NPORTS  = 4;
  localparam int TRK_W   = 10;
  localparam int FIELD_W = 3;

  typedef struct packed {
    logic hw_err;
    logic busy_err;
    logic not_ready;
  } port_field_t;
endpackage

// File: rtl/seek_cmd_dec.sv
module seek_cmd_dec #(
  parameter int PORTS = seek_pkg::NPORTS,
  parameter int TRK_W = seek_pkg::TRK_W,
  localparam int PSEL_W = $clog2(PORTS),
  localparam int CMD_W  = PSEL_W + TRK_W
) (
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_word,
  output logic [PORTS-1:0]  req,
  output logic [TRK_W-1:0]  trk
);
  logic [PSEL_W-1:0] sel;
  assign sel = cmd_word[CMD_W-1 -: PSEL_W];
  assign trk = cmd_word[TRK_W-1:0];

  for (genvar p = 0; p < PORTS; p++) begin : g_req
    assign req[p] = cmd_valid && (sel == PSEL_W'(p));
  end
endmodule

// File: rtl/seek_port_ctrl.sv
module seek_port_ctrl
  import seek_pkg::*;
#(
  parameter int TRK_W = seek_pkg::TRK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclr,
  input  logic             req,
  input  logic [TRK_W-1:0] trk,
  input  logic [TRK_W-1:0] max_trk,
  input  logic             present,
  input  logic             ready,
  input  logic             xfer_here,
  input  logic             seek_done,
  input  logic             fault,
  output logic             seek_strobe,
  output logic [TRK_W-1:0] seek_track,
  output logic             restore_strobe,
  output logic             seek_end,
  output port_field_t      field
);
  logic moving, busy_err, hw_err;
  logic reject, over;

  assign reject   = !present || !ready || moving || xfer_here;
  assign over     = trk > max_trk;
  assign seek_end = !mclr && moving && (fault || seek_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moving         <= 1'b0;
      busy_err       <= 1'b0;
      hw_err         <= 1'b0;
      seek_strobe    <= 1'b0;
      restore_strobe <= 1'b0;
      seek_track     <= '0;
    end else begin
      seek_strobe    <= 1'b0;
      restore_strobe <= 1'b0;
      if (mclr) begin
        moving   <= 1'b0;
        busy_err <= 1'b0;
        hw_err   <= 1'b0;
      end else begin
        if (moving && fault) begin
          moving         <= 1'b0;
          hw_err         <= 1'b1;
          restore_strobe <= 1'b1;
        end else if (moving && seek_done) begin
          moving <= 1'b0;
        end
        if (req) begin
          if (reject) begin
            busy_err <= 1'b1;
          end else begin
            busy_err <= 1'b0;
            if (over) begin
              hw_err <= 1'b1;
            end else begin
              hw_err      <= 1'b0;
              moving      <= 1'b1;
              seek_strobe <= 1'b1;
              seek_track  <= trk;
            end
          end
        end
      end
    end
  end

  assign field = present ? {hw_err, busy_err, (moving || !ready)} : 3'b111;

  assert_strobe_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seek_strobe |-> (!busy_err && !hw_err));
  assert_strobe_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seek_strobe |-> (seek_track <= $past(max_trk)));
  assert_restore_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_strobe |-> (hw_err && !moving));
  assert_xfer_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && xfer_here && !mclr) |=> (busy_err && !seek_strobe));
  assert_mclr_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (!busy_err && !hw_err && !moving));
endmodule

// File: rtl/seek_done_ctl.sv
module seek_done_ctl #(
  parameter int PORTS = seek_pkg::NPORTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] seek_end,
  input  logic             xfer_active,
  input  logic             irq_en,
  output logic             done_o,
  output logic             irq_o
);
  logic fire;
  assign fire = (|seek_end) && !xfer_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      done_o <= fire;
      irq_o  <= fire && irq_en;
    end
  end

  assert_done_no_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(!xfer_active));
  assert_irq_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (done_o && $past(irq_en)));
endmodule

// File: rtl/seek_overlap_mgr.sv
module seek_overlap_mgr
  import seek_pkg::*;
#(
  parameter int PORTS = seek_pkg::NPORTS,
  parameter int TRK_W = seek_pkg::TRK_W,
  localparam int PSEL_W = $clog2(PORTS),
  localparam int CMD_W  = PSEL_W + TRK_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mclr,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [CMD_W-1:0]       cmd_word,
  input  logic                   xfer_active,
  input  logic [PSEL_W-1:0]      xfer_port,
  input  logic                   irq_en,
  input  logic [PORTS-1:0]       drv_present,
  input  logic [PORTS-1:0]       drv_ready,
  input  logic [PORTS-1:0]       drv_seek_done,
  input  logic [PORTS-1:0]       drv_fault,
  input  logic [PORTS*TRK_W-1:0] max_track,
  output logic [PORTS-1:0]       seek_strobe,
  output logic [PORTS*TRK_W-1:0] seek_track,
  output logic [PORTS-1:0]       restore_strobe,
  output logic [PORTS*FIELD_W-1:0] seek_status,
  output logic                   done_o,
  output logic                   irq_o
);
  logic [PORTS-1:0] req, seek_end;
  logic [TRK_W-1:0] trk;

  assign cmd_ready = 1'b1;

  seek_cmd_dec #(.PORTS(PORTS), .TRK_W(TRK_W)) u_dec (
    .cmd_valid(cmd_valid),
    .cmd_word (cmd_word),
    .req      (req),
    .trk      (trk)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    port_field_t fld;
    seek_port_ctrl #(.TRK_W(TRK_W)) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .mclr          (mclr),
      .req           (req[p]),
      .trk           (trk),
      .max_trk       (max_track[p*TRK_W +: TRK_W]),
      .present       (drv_present[p]),
      .ready         (drv_ready[p]),
      .xfer_here     (xfer_active && (xfer_port == PSEL_W'(p))),
      .seek_done     (drv_seek_done[p]),
      .fault         (drv_fault[p]),
      .seek_strobe   (seek_strobe[p]),
      .seek_track    (seek_track[p*TRK_W +: TRK_W]),
      .restore_strobe(restore_strobe[p]),
      .seek_end      (seek_end[p]),
      .field         (fld)
    );
    assign seek_status[p*FIELD_W +: FIELD_W] = fld;
  end

  seek_done_ctl #(.PORTS(PORTS)) u_done (
    .clk        (clk),
    .rst_n      (rst_n),
    .seek_end   (seek_end),
    .xfer_active(xfer_active),
    .irq_en     (irq_en),
    .done_o     (done_o),
    .irq_o      (irq_o)
  );

  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(seek_strobe));
endmodule

// File: tb/seek_overlap_mgr_tb.sv
module seek_overlap_mgr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [11:0] cmd_word = '0;
  logic xfer_active = 1'b0;
  logic [1:0] xfer_port = '0;
  logic irq_en = 1'b0;
  logic [3:0] drv_present = 4'hF;
  logic [3:0] drv_ready = 4'hF;
  logic [3:0] drv_seek_done = '0;
  logic [3:0] drv_fault = '0;
  logic [39:0] max_track = {4{10'h3FF}};
  logic [3:0] seek_strobe, restore_strobe;
  logic [39:0] seek_track;
  logic [11:0] seek_status;
  logic done_o, irq_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int lat[4] = '{5, 5, 5, 5};
  bit fmode[4] = '{0, 0, 0, 0};
  int cnt[4] = '{0, 0, 0, 0};
  int n_strobe[4] = '{0, 0, 0, 0};
  int n_rest[4] = '{0, 0, 0, 0};
  int n_done = 0, n_irq = 0;

  always #2.5 clk = ~clk;

  seek_overlap_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .xfer_active(xfer_active), .xfer_port(xfer_port), .irq_en(irq_en),
    .drv_present(drv_present), .drv_ready(drv_ready), .drv_seek_done(drv_seek_done),
    .drv_fault(drv_fault), .max_track(max_track), .seek_strobe(seek_strobe),
    .seek_track(seek_track), .restore_strobe(restore_strobe), .seek_status(seek_status),
    .done_o(done_o), .irq_o(irq_o)
  );

  // Drive models with programmable latency, plus event counters
  always @(negedge clk) begin
    for (int p = 0; p < 4; p++) begin
      drv_seek_done[p] = 1'b0;
      drv_fault[p] = 1'b0;
      if (cnt[p] > 0) begin
        cnt[p]--;
        if (cnt[p] == 0) begin
          if (fmode[p]) drv_fault[p] = 1'b1;
          else drv_seek_done[p] = 1'b1;
        end
      end
      if (seek_strobe[p]) begin
        cnt[p] = lat[p];
        n_strobe[p]++;
      end
      if (restore_strobe[p]) n_rest[p]++;
    end
    if (done_o) n_done++;
    if (irq_o) n_irq++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic int pack(input int f3, input int f2, input int f1, input int f0);
    return (f3 << 9) | (f2 << 6) | (f1 << 3) | f0;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic seek(input int port, input int trk);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word = 12'((port << 10) | trk);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_mclr();
    @(negedge clk);
    mclr = 1'b1;
    @(negedge clk);
    mclr = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R2 reset status", seek_status, 0);
    check("R1 cmd_ready high", cmd_ready, 1);
    check("R9 no done at reset", done_o, 0);
  endtask

  task automatic t_absent();
    drv_present[2] = 1'b0;
    idle(1);
    check("R4 absent port reads 7", seek_status, pack(0, 7, 0, 0));
    seek(2, 5);
    check("R5 absent port no strobe", n_strobe[2], 0);
    drv_present[2] = 1'b1;
    idle(1);
    check("R5 busy error from absent", seek_status, pack(0, 2, 0, 0));
    pulse_mclr();
    check("R11 mclr clears busy", seek_status, 0);
  endtask

  task automatic t_basic();
    lat[1] = 5;
    seek(1, 10'h155);
    check("R1 strobe port1", n_strobe[1], 1);
    check("R1 track port1", seek_track[19:10], 10'h155);
    check("R3 moving not ready", seek_status, pack(0, 0, 1, 0));
    idle(10);
    check("R9 done after seek", n_done, 1);
    check("R10 no irq when disabled", n_irq, 0);
    check("R3 ready after seek", seek_status, 0);
  endtask

  task automatic t_busy();
    lat[0] = 20;
    seek(0, 3);
    check("R3 port0 moving", seek_status, pack(0, 0, 0, 1));
    seek(0, 9);
    check("R5 busy err while moving", seek_status, pack(0, 0, 0, 3));
    check("R5 no second strobe", n_strobe[0], 1);
    idle(25);
    check("R5 busy err stays", seek_status, pack(0, 0, 0, 2));
    check("R9 done count", n_done, 2);
    lat[0] = 2;
    seek(0, 4);
    check("R6 accept clears busy err", seek_status, pack(0, 0, 0, 1));
    idle(5);
    check("R9 done count 3", n_done, 3);
  endtask

  task automatic t_overlap();
    irq_en = 1'b1;
    lat[2] = 8; lat[3] = 3;
    seek(2, 20);
    seek(3, 30);
    check("R12 both moving", seek_status, pack(1, 1, 0, 0));
    check("R1 track port3", seek_track[39:30], 30);
    check("R1 track port2", seek_track[29:20], 20);
    idle(12);
    check("R12 both done", n_done, 5);
    check("R10 irq per done", n_irq, 2);
    check("R12 both idle", seek_status, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_xfer();
    xfer_active = 1'b1; xfer_port = 2'd1;
    seek(1, 7);
    check("R5 xfer port rejected", seek_status, pack(0, 0, 2, 0));
    check("R5 xfer port no strobe", n_strobe[1], 1);
    lat[0] = 4;
    seek(0, 8);
    check("R12 other port accepted", seek_status, pack(0, 0, 2, 1));
    idle(8);
    check("R9 done suppressed in xfer", n_done, 5);
    check("R9 port0 idle", seek_status, pack(0, 0, 2, 0));
    xfer_active = 1'b0;
    pulse_mclr();
    check("R11 mclr clears", seek_status, 0);
  endtask

  task automatic t_not_ready();
    drv_ready[3] = 1'b0;
    idle(1);
    check("R3 not ready live", seek_status, pack(1, 0, 0, 0));
    seek(3, 1);
    check("R5 not ready rejected", seek_status, pack(3, 0, 0, 0));
    check("R5 not ready no strobe", n_strobe[3], 1);
    drv_ready[3] = 1'b1;
    idle(1);
    check("R3 ready again", seek_status, pack(2, 0, 0, 0));
    pulse_mclr();
  endtask

  task automatic t_range();
    max_track[29:20] = 10'd100;
    seek(2, 101);
    check("R7 over max hw err", seek_status, pack(0, 4, 0, 0));
    check("R7 over max no strobe", n_strobe[2], 1);
    lat[2] = 2;
    seek(2, 100);
    check("R6 accept clears hw err", seek_status, pack(0, 1, 0, 0));
    check("R7 at max strobes", n_strobe[2], 2);
    idle(5);
    check("R9 done count 6", n_done, 6);
  endtask

  task automatic t_fault();
    fmode[0] = 1'b1; lat[0] = 3;
    seek(0, 7);
    idle(6);
    check("R8 fault hw err", seek_status, pack(0, 0, 0, 4));
    check("R8 restore strobe", n_rest[0], 1);
    check("R9 fault ends seek done", n_done, 7);
    fmode[0] = 1'b0; lat[0] = 10;
    seek(0, 2);
    check("R6 clears after fault", seek_status, pack(0, 0, 0, 1));
    pulse_mclr();
    check("R11 mclr abandons seek", seek_status, 0);
    idle(15);
    check("R11 late completion ignored", n_done, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_absent();
    t_basic();
    t_busy();
    t_overlap();
    t_xfer();
    t_not_ready();
    t_range();
    t_fault();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule